// File: doc/BRIEF.md
# Serial/Parallel FIFO Word Intake Register

This block is the entry stage of a fall-through FIFO that is four bits wide by default. It collects one word and hands it to the stack. A word arrives in one of two ways. In parallel, it is copied from a data bus for as long as a level-sensitive load strobe is high. Serially, one bit is taken on each falling edge of a serial clock while an active-low serial enable is asserted.

The register has one stage per data bit plus a marker stage. Initialization presets the top data stage and clears the rest. Serial bits enter at the top and move toward the bottom, so the preset one bit reaches the marker exactly when a word is complete. A set marker drives the active-low full flag low and blocks further serial clocks.

The stack pulls the word with an active-low transfer request, provided its top slot is empty. A push pulse marks the transfer. A done flag then stops the same word from being pushed a second time. The register returns to its initial value once the load strobe is low. Wiring the full flag to the transfer request gives automatic FIFO action.

The serial clock, serial enable, serial data and load strobe are synchronized to the system clock. The parallel data bus is sampled directly.

Top module: `fifo_word_intake`

## Requirements
- R1: During reset and after it, word_o equals the initial pattern (only the top bit set, 4'b1000 for WIDTH=4), full_n is 1 and push_o is 0.
- R2: While load_i is high, word_o follows par_d (bit i of par_d into bit i of word_o) and full_n is 0. This takes effect within SYNC_STAGES+1 clock cycles.
- R3: With ser_en_n low, each falling edge of ser_clk_i shifts word_o right by one bit. ser_d enters bit WIDTH-1, and the bit leaving bit 0 moves into the marker. After WIDTH edges the first bit is in bit 0 and full_n is 0.
- R4: A falling edge of ser_clk_i while ser_en_n is high leaves word_o and full_n unchanged.
- R5: Once full_n is 0, further serial clock edges leave word_o unchanged.
- R6: push_o is 1 in a cycle exactly when xfer_n is 0, stack_ready is 1, full_n is 0 and the current word has not yet been pushed. word_o carries the word in that cycle.
- R7: Each word is pushed only once. full_n stays 0 for as long as load_i is high after a push. Once load_i is low, word_o returns to the initial pattern and full_n returns to 1.
- R8: When a parallel load and a serial shift fall in the same cycle, the parallel load wins.
- R9: With full_n driving xfer_n and stack_ready high, each serially entered word is pushed exactly once and the register then empties itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Parallel load strobe, level sensitive, active high |
| par_d | input | WIDTH | Parallel data word |
| ser_clk_i | input | 1 | Serial clock; a bit is taken on its falling edge |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_d | input | 1 | Serial data bit |
| xfer_n | input | 1 | Transfer request to the stack, active low |
| stack_ready | input | 1 | Top slot of the stack is empty |
| full_n | output | 1 | Word-complete flag, active low |
| push_o | output | 1 | Push strobe into the stack |
| word_o | output | WIDTH | Register contents, i.e. the word offered to the stack |

## Verification
Serial entry is tried with a mixed bit string. Every intermediate value is checked, which separates the correct shift direction and the marker travel from a reversed or mis-ended chain. Parallel entry is tried with held and with short strobes. A one-cycle load that coincides with a serial edge shows whether load beats shift. A load held across a transfer separates a single push from repeated pushes, and shows whether re-initialization is delayed. A disabled serial clock, extra clocks on a full register, a stack that is not ready, and a self-timed loop with the full flag driving the request each isolate one gating condition.

// File: rtl/fifo_word_intake.sv
module fifo_word_intake #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] par_d,
  input  logic             ser_clk_i,
  input  logic             ser_en_n,
  input  logic             ser_d,
  input  logic             xfer_n,
  input  logic             stack_ready,
  output logic             full_n,
  output logic             push_o,
  output logic [WIDTH-1:0] word_o
);

  localparam logic [WIDTH-1:0] INIT = {1'b1, {(WIDTH-1){1'b0}}};
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0]     load_q, sclk_q, en_q, sd_q;
  logic             sclk_last;
  logic [WIDTH-1:0] stage;
  logic             marker, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q    <= '0;
      sclk_q    <= '0;
      en_q      <= '1;
      sd_q      <= '0;
      sclk_last <= 1'b0;
    end else begin
      load_q    <= {load_q[TOP-1:0], load_i};
      sclk_q    <= {sclk_q[TOP-1:0], ser_clk_i};
      en_q      <= {en_q[TOP-1:0], ser_en_n};
      sd_q      <= {sd_q[TOP-1:0], ser_d};
      sclk_last <= sclk_q[TOP];
    end
  end

  wire load_s = load_q[TOP];
  wire shift  = sclk_last & ~sclk_q[TOP] & ~en_q[TOP] & ~marker;
  wire reinit = done & ~load_s;

  assign push_o = ~xfer_n & stack_ready & marker & ~done;
  assign full_n = ~marker;
  assign word_o = stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= INIT;
      marker <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (reinit) begin
        stage  <= INIT;
        marker <= 1'b0;
      end else if (load_s) begin
        stage  <= par_d;
        marker <= 1'b1;
      end else if (shift) begin
        stage  <= {sd_q[TOP], stage[WIDTH-1:1]};
        marker <= stage[0];
      end
      if (push_o)      done <= 1'b1;
      else if (reinit) done <= 1'b0;
    end
  end

endmodule

module fifo_word_intake_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full_n,
  input logic             push_o,
  input logic             stack_ready,
  input logic             xfer_n,
  input logic [WIDTH-1:0] word_o
);
  localparam logic [WIDTH-1:0] INIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic was_rst = 1'b0;
  always @(posedge clk) begin
    if (rst_n && was_rst)
      AST_RESET_VALUE: assert (full_n && !push_o && word_o == INIT); // R1
    was_rst <= !rst_n;
  end

  AST_PUSH_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (stack_ready && !xfer_n)); // R6
  AST_NO_PUSH_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    full_n |-> !push_o); // R6
  AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !push_o); // R7
  AST_FULL_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !full_n); // R7
  AST_REINIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_n) |-> (word_o == INIT)); // R7
endmodule

bind fifo_word_intake fifo_word_intake_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .full_n(full_n), .push_o(push_o),
  .stack_ready(stack_ready), .xfer_n(xfer_n), .word_o(word_o)
);

// File: tb/tb_fifo_word_intake.sv
module tb_fifo_word_intake;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [3:0] par_d = '0;
  logic       ser_clk_i = 1'b0;
  logic       ser_en_n = 1'b1;
  logic       ser_d = 1'b0;
  logic       xfer_man = 1'b1;
  logic       auto_mode = 1'b0;
  logic       stack_ready = 1'b0;
  logic       full_n, push_o, xfer_n;
  logic [3:0] word_o;

  int checks = 0;
  int fails  = 0;
  int pushes = 0;
  logic [3:0] last_push = '0;

  always #2 clk = ~clk;
  assign xfer_n = auto_mode ? full_n : xfer_man;

  fifo_word_intake dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .par_d(par_d),
    .ser_clk_i(ser_clk_i), .ser_en_n(ser_en_n), .ser_d(ser_d),
    .xfer_n(xfer_n), .stack_ready(stack_ready),
    .full_n(full_n), .push_o(push_o), .word_o(word_o)
  );

  always @(posedge clk) if (push_o) begin
    pushes    <= pushes + 1;
    last_push <= word_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(input bit b);
    ser_d = b; ser_clk_i = 1'b1; cyc(3);
    ser_clk_i = 1'b0; cyc(4);
  endtask

  task automatic flush();
    stack_ready = 1'b1; xfer_man = 1'b0; cyc(1);
    xfer_man = 1'b1; cyc(4);
  endtask

  task automatic t_reset();
    check(word_o == 4'b1000, "R1 word", word_o, 4'b1000);
    check(full_n == 1'b1, "R1 full_n", full_n, 1);
    check(push_o == 1'b0, "R1 push", push_o, 0);
  endtask

  task automatic t_parallel();
    int p0 = pushes;
    par_d = 4'hA; load_i = 1'b1; cyc(5);
    check(word_o == 4'hA, "R2 word", word_o, 4'hA);
    check(full_n == 1'b0, "R2 full_n", full_n, 0);
    load_i = 1'b0; cyc(5);
    stack_ready = 1'b1; xfer_man = 1'b0; #1;
    check(push_o == 1'b1 && word_o == 4'hA, "R6 push", {push_o, word_o}, 5'h1A);
    cyc(1);
    check(push_o == 1'b0, "R7 no second push", push_o, 0);
    cyc(4);
    xfer_man = 1'b1;
    check(pushes - p0 == 1, "R7 push count", pushes - p0, 1);
    check(word_o == 4'b1000 && full_n, "R7 reinit", {full_n, word_o}, 5'h18);
  endtask

  task automatic t_not_ready();
    par_d = 4'h5; load_i = 1'b1; cyc(5); load_i = 1'b0; cyc(4);
    stack_ready = 1'b0; xfer_man = 1'b0; cyc(3); #1;
    check(push_o == 1'b0 && !full_n, "R6 stack busy", {full_n, push_o}, 0);
    xfer_man = 1'b1; flush();
  endtask

  task automatic t_hold_load();
    int p0 = pushes;
    stack_ready = 1'b1; xfer_man = 1'b0;
    par_d = 4'h3; load_i = 1'b1; cyc(12);
    check(pushes - p0 == 1, "R7 one push under held load", pushes - p0, 1);
    check(!full_n && word_o == 4'h3, "R7 reinit deferred", {full_n, word_o}, 5'h03);
    load_i = 1'b0; xfer_man = 1'b1; cyc(6);
    check(full_n && word_o == 4'b1000, "R7 reinit after load low", {full_n, word_o}, 5'h18);
    check(pushes - p0 == 1, "R7 still one push", pushes - p0, 1);
  endtask

  task automatic t_serial();
    logic [3:0] exp = 4'b1000;
    logic [3:0] bits = 4'b1101;
    logic       mk = 1'b0;
    stack_ready = 1'b0; ser_en_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ser_bit(bits[i]);
      mk  = exp[0];
      exp = {bits[i], exp[3:1]};
      check(word_o == exp, "R3 shift value", word_o, exp);
      check(full_n == !mk, "R3 marker", full_n, !mk);
    end
    ser_bit(1'b0); ser_bit(1'b0);
    check(word_o == 4'hD && !full_n, "R5 clocks ignored when full", word_o, 4'hD);
    ser_en_n = 1'b1; flush();
  endtask

  task automatic t_disabled();
    ser_en_n = 1'b1; ser_bit(1'b1); ser_bit(1'b0);
    check(word_o == 4'b1000 && full_n, "R4 disabled serial clock", {full_n, word_o}, 5'h18);
  endtask

  task automatic t_priority();
    ser_en_n = 1'b0; ser_d = 1'b1; ser_clk_i = 1'b1; par_d = 4'h6; cyc(4);
    ser_clk_i = 1'b0; load_i = 1'b1; cyc(1);
    load_i = 1'b0; cyc(5);
    check(word_o == 4'h6 && !full_n, "R8 load beats shift", {full_n, word_o}, 5'h06);
    ser_en_n = 1'b1; flush();
  endtask

  task automatic t_auto();
    int p0 = pushes;
    auto_mode = 1'b1; stack_ready = 1'b1; ser_en_n = 1'b0;
    ser_bit(1'b0); ser_bit(1'b1); ser_bit(1'b1); ser_bit(1'b0);
    cyc(4);
    check(pushes - p0 == 1, "R9 auto push count", pushes - p0, 1);
    check(last_push == 4'h6, "R9 auto pushed word", last_push, 4'h6);
    check(full_n && word_o == 4'b1000, "R9 auto empties", {full_n, word_o}, 5'h18);
    auto_mode = 1'b0; ser_en_n = 1'b1;
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1; cyc(2);
    t_reset();
    t_parallel();
    t_not_ready();
    t_hold_load();
    t_serial();
    t_disabled();
    t_priority();
    t_auto();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule